// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block is the control front end of a clock synthesizer. It produces the settings the frequency dividers use: a 9-bit feedback divider value M, a 2-bit output divider code N and a spread-spectrum enable bit. It also raises a flag whenever M lies outside a parameterized window in which the loop can lock. The settings arrive by one of two routes. The first is a 9-bit parallel bus qualified by an active-low parallel load strobe. The second is a three-wire serial port with a serial clock, serial data and a load strobe.

All external strobes and data bits are resampled into the system clock through a synchronizer chain. Edges of the serial clock and the serial load strobe are then detected from the synchronized samples, so the whole block runs on a single clock.

Parallel loading is transparent while its strobe is low, and the value is frozen when the strobe returns high. Serial words are shifted in on rising serial clock edges and transferred when the load strobe rises. While the load strobe stays high the transfer is transparent, and it is latched once the load strobe falls. A master reset input is passed on, synchronized, to the downstream dividers and leaves the loaded settings alone.

Top module: `synth_cfg_loader`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets M to the value on the parallel pins, N to code 01 and the spread-spectrum enable to 0.
- R2: While par_load_n_i is low, M follows par_m_i, three clock cycles after each pin change.
- R3: When par_load_n_i goes high, M holds the last value it followed, even if par_m_i changes afterwards.
- R4: While par_load_n_i is low, N is forced to code 01 (divide by 2) and the spread-spectrum enable keeps its value.
- R5: While par_load_n_i is high, each rising edge of ser_clk_i shifts ser_dat_i into the shift register. While ser_load_i is low, these shifts do not change M, N or the spread-spectrum enable.
- R6: A serial word is 14 bits, sent first to last as: two ignored slots, spread-spectrum enable, N bit 1, N bit 0, then M bit 8 down to M bit 0. The bit sent last ends up in M bit 0.
- R7: A rising edge of ser_load_i (with par_load_n_i high) copies the shift register into M, N and the spread-spectrum enable.
- R8: While ser_load_i stays high, each rising edge of ser_clk_i updates M, N and the spread-spectrum enable with the newly shifted contents.
- R9: After ser_load_i falls, further shifts leave M, N and the spread-spectrum enable unchanged.
- R10: While par_load_n_i is low, serial clock edges do not shift the register and ser_load_i edges transfer nothing.
- R11: div_reset_o follows mrst_i two cycles later, and master reset does not change M, N or the spread-spectrum enable.
- R12: m_out_of_range_o is high exactly when M is below M_MIN (default 125) or above M_MAX (default 350), in the same cycle as M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_m_i | input | 9 | Parallel feedback divider value |
| par_load_n_i | input | 1 | Parallel load strobe, low = transparent |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_dat_i | input | 1 | Serial data |
| ser_load_i | input | 1 | Serial transfer strobe |
| mrst_i | input | 1 | Master reset request for the dividers |
| m_div_o | output | 9 | Feedback divider value M |
| n_code_o | output | 2 | Output divider code: 00 /1, 01 /2, 10 /4, 11 /8 |
| ssc_en_o | output | 1 | Spread-spectrum enable |
| m_out_of_range_o | output | 1 | M lies outside the lock window |
| div_reset_o | output | 1 | Synchronized master reset for the dividers |

## Verification
Each pin change reaches the configuration registers after three clock cycles: two synchronizer stages and the register itself. The range flag appears in the same cycle as M, and div_reset_o appears after two cycles. The bench drives inputs on falling clock edges and waits at least that many falling edges before it samples. Between a change of serial data and the serial clock edge that uses it, the bench leaves three cycles, so the synchronized order of data and clock matches the order on the pins. A reference model of the shift register in the bench predicts the fields after each transparent update.

// File: rtl/synth_cfg_pkg.sv
// Package: shared types for the synthesizer configuration loader.
// Assumes the output divider code is always two bits wide.
package synth_cfg_pkg;

    localparam int NDIV_W = 2;

    // Control strobes after synchronization, MSB first as concatenated at the top.
    typedef struct packed {
        logic pload_n;
        logic sclk;
        logic sdat;
        logic sload;
        logic mrst;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Idle levels: parallel strobe inactive high, everything else low.
    localparam ctl_t CTL_IDLE = ctl_t'(5'b10000);

    typedef enum logic [NDIV_W-1:0] {
        NDIV_1 = 2'b00,
        NDIV_2 = 2'b01,
        NDIV_4 = 2'b10,
        NDIV_8 = 2'b11
    } ndiv_e;

endpackage

// File: rtl/synth_cfg_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is quasi-static relative to clk or that bit-skew is harmless.
module synth_cfg_sync #(
    parameter int             W        = 1,
    parameter int             STAGES   = 2,
    parameter logic [W-1:0]   RST_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= d;
            end
        end else begin : g_next
            // Later stages resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/synth_cfg_edge.sv
// Module: rising-edge detection on synchronized serial clock and load strobe.
// Assumes inputs are already in the clk domain.
module synth_cfg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic sload,
    output logic sclk_rise,
    output logic sload_rise
);

    logic sclk_d;
    logic sload_d;

    // Remember previous samples; idle low after reset so no false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            sload_d <= 1'b0;
        end else begin
            sclk_d  <= sclk;
            sload_d <= sload;
        end
    end

    assign sclk_rise  = sclk  & ~sclk_d;
    assign sload_rise = sload & ~sload_d;

endmodule

// File: rtl/synth_cfg_shreg.sv
// Module: serial payload shift register.
// Holds only the payload width; leading filler slots fall off the far end.
// next_o shows the contents after the current shift, or the held contents
// when no shift is pending, so a transfer can use it in either case.
module synth_cfg_shreg #(
    parameter int PAY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [PAY_W-1:0] next_o
);

    logic [PAY_W-1:0] q;

    // Compute the post-shift view.
    always_comb begin
        if (shift_en) next_o = {q[PAY_W-2:0], din};
        else          next_o = q;
    end

    // Shift on enable, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= next_o;
    end

endmodule

// File: rtl/synth_cfg_regs.sv
// Module: M / N / spread-spectrum configuration registers and range flag.
// Parallel mode has priority; serial transfers apply only outside it.
// Reset loads M straight from the raw parallel pins.
module synth_cfg_regs
    import synth_cfg_pkg::*;
#(
    parameter int M_W   = 9,
    parameter int M_MIN = 125,
    parameter int M_MAX = 350,
    localparam int PAY_W = M_W + NDIV_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [M_W-1:0]   rst_m,
    input  logic             par_mode,
    input  logic [M_W-1:0]   par_m,
    input  logic             ser_xfer,
    input  logic [PAY_W-1:0] payload,
    output logic [M_W-1:0]   m_o,
    output ndiv_e            n_o,
    output logic             ssc_o,
    output logic             range_err_o
);

    localparam logic [M_W-1:0] LO = M_W'(M_MIN);
    localparam logic [M_W-1:0] HI = M_W'(M_MAX);

    logic [M_W-1:0] m_q;
    ndiv_e          n_q;
    logic           ssc_q;

    // Update the configuration from reset, parallel or serial source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q   <= rst_m;
            n_q   <= NDIV_2;
            ssc_q <= 1'b0;
        end else if (par_mode) begin
            m_q   <= par_m;
            n_q   <= NDIV_2;
        end else if (ser_xfer) begin
            m_q   <= payload[M_W-1:0];
            n_q   <= ndiv_e'(payload[M_W+NDIV_W-1:M_W]);
            ssc_q <= payload[PAY_W-1];
        end
    end

    // Flag divider values outside the lock window.
    always_comb begin
        range_err_o = (m_q < LO) || (m_q > HI);
    end

    assign m_o   = m_q;
    assign n_o   = n_q;
    assign ssc_o = ssc_q;

endmodule

// File: rtl/synth_cfg_loader.sv
// Module: configuration loader top. Synchronizes all pins, detects serial
// edges, shifts the serial payload and arbitrates parallel and serial loads.
// Assumes one system clock fast enough to oversample the serial port.
module synth_cfg_loader
    import synth_cfg_pkg::*;
#(
    parameter int M_W         = 9,
    parameter int SYNC_STAGES = 2,
    parameter int M_MIN       = 125,
    parameter int M_MAX       = 350
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [M_W-1:0]   par_m_i,
    input  logic             par_load_n_i,
    input  logic             ser_clk_i,
    input  logic             ser_dat_i,
    input  logic             ser_load_i,
    input  logic             mrst_i,
    output logic [M_W-1:0]   m_div_o,
    output logic [1:0]       n_code_o,
    output logic             ssc_en_o,
    output logic             m_out_of_range_o,
    output logic             div_reset_o
);

    localparam int PAY_W  = M_W + NDIV_W + 1;
    localparam int SYNC_W = M_W + CTL_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {{M_W{1'b0}}, CTL_IDLE};

    logic [SYNC_W-1:0] raw_vec;
    logic [SYNC_W-1:0] s_vec;
    logic [M_W-1:0]    s_m;
    ctl_t              s_ctl;
    logic              sclk_rise;
    logic              sload_rise;
    logic              shift_en;
    logic              ser_xfer;
    logic              par_mode;
    logic [PAY_W-1:0]  payload;
    ndiv_e             n_val;

    assign raw_vec = {par_m_i, par_load_n_i, ser_clk_i, ser_dat_i, ser_load_i, mrst_i};

    synth_cfg_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_vec),
        .q     (s_vec)
    );

    assign s_m   = s_vec[SYNC_W-1:CTL_W];
    assign s_ctl = ctl_t'(s_vec[CTL_W-1:0]);

    synth_cfg_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (s_ctl.sclk),
        .sload      (s_ctl.sload),
        .sclk_rise  (sclk_rise),
        .sload_rise (sload_rise)
    );

    // Mode arbitration: parallel strobe low wins; serial acts only when it is high.
    always_comb begin
        par_mode = ~s_ctl.pload_n;
        shift_en = s_ctl.pload_n & sclk_rise;
        ser_xfer = s_ctl.pload_n & s_ctl.sload & (sload_rise | sclk_rise);
    end

    synth_cfg_shreg #(
        .PAY_W (PAY_W)
    ) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (s_ctl.sdat),
        .next_o   (payload)
    );

    synth_cfg_regs #(
        .M_W   (M_W),
        .M_MIN (M_MIN),
        .M_MAX (M_MAX)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_m       (par_m_i),
        .par_mode    (par_mode),
        .par_m       (s_m),
        .ser_xfer    (ser_xfer),
        .payload     (payload),
        .m_o         (m_div_o),
        .n_o         (n_val),
        .ssc_o       (ssc_en_o),
        .range_err_o (m_out_of_range_o)
    );

    assign n_code_o    = n_val;
    assign div_reset_o = s_ctl.mrst;

endmodule

// File: rtl/synth_cfg_loader_chk.sv
// Module: assertion checker for the configuration loader, bound to the top.
// Assumes the default two-stage synchronizer (three-cycle pin-to-register path).
module synth_cfg_loader_chk #(
    parameter int M_W = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic [M_W-1:0] par_m_i,
    input logic           par_load_n_i,
    input logic           ser_load_i,
    input logic           mrst_i,
    input logic [M_W-1:0] m_div_o,
    input logic [1:0]     n_code_o,
    input logic           ssc_en_o,
    input logic           div_reset_o
);

    logic [2:0] since_rst;

    // Count cycles since reset so no property looks back across it.
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 7) since_rst <= since_rst + 3'd1;
    end

    // R2: parallel pins reach M three cycles later while the strobe is low.
    a_r2_par_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd5 && !$past(par_load_n_i, 3)) |-> (m_div_o == $past(par_m_i, 3)));

    // R4: parallel mode forces the divide-by-2 code.
    a_r4_par_ndiv2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd5 && !$past(par_load_n_i, 3)) |-> (n_code_o == 2'b01));

    // R9: with no parallel and no serial load activity, the settings hold.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd6 && $past(par_load_n_i, 3) && $past(par_load_n_i, 4)
         && !$past(ser_load_i, 3) && !$past(ser_load_i, 4))
        |-> ($stable(m_div_o) && $stable(n_code_o) && $stable(ssc_en_o)));

    // R11: master reset reaches the dividers two cycles later.
    a_r11_mrst_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4) |-> (div_reset_o == $past(mrst_i, 2)));

endmodule

bind synth_cfg_loader synth_cfg_loader_chk #(.M_W(M_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .par_m_i      (par_m_i),
    .par_load_n_i (par_load_n_i),
    .ser_load_i   (ser_load_i),
    .mrst_i       (mrst_i),
    .m_div_o      (m_div_o),
    .n_code_o     (n_code_o),
    .ssc_en_o     (ssc_en_o),
    .div_reset_o  (div_reset_o)
);

// File: tb/synth_cfg_loader_tb.sv
// Directed bench for the configuration loader: one task per scenario.
module synth_cfg_loader_tb;

    localparam int CLK_PERIOD = 10;
    localparam int M_W        = 9;
    localparam int PAY_W      = 12;
    localparam int FRAME_LEN  = 14;
    localparam int LAT        = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [M_W-1:0] par_m_i = 9'd200;
    logic           par_load_n_i = 1'b1;
    logic           ser_clk_i = 1'b0;
    logic           ser_dat_i = 1'b0;
    logic           ser_load_i = 1'b0;
    logic           mrst_i = 1'b0;
    logic [M_W-1:0] m_div_o;
    logic [1:0]     n_code_o;
    logic           ssc_en_o;
    logic           m_out_of_range_o;
    logic           div_reset_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [PAY_W-1:0] sr_model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_cfg_loader u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .par_m_i          (par_m_i),
        .par_load_n_i     (par_load_n_i),
        .ser_clk_i        (ser_clk_i),
        .ser_dat_i        (ser_dat_i),
        .ser_load_i       (ser_load_i),
        .mrst_i           (mrst_i),
        .m_div_o          (m_div_o),
        .n_code_o         (n_code_o),
        .ssc_en_o         (ssc_en_o),
        .m_out_of_range_o (m_out_of_range_o),
        .div_reset_o      (div_reset_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_cfg(input string tag, input int m, input int n, input int ssc);
        chk({tag, " M"}, 32'(m_div_o), 32'(m));
        chk({tag, " N"}, 32'(n_code_o), 32'(n));
        chk({tag, " SSC"}, 32'(ssc_en_o), 32'(ssc));
    endtask

    // One serial bit: data settles, then a clock pulse; model shifts if live.
    task automatic send_bit(input logic b, input bit live);
        ser_dat_i = b;
        tick(LAT);
        ser_clk_i = 1'b1;
        tick(LAT);
        ser_clk_i = 1'b0;
        tick(LAT);
        if (live) sr_model = {sr_model[PAY_W-2:0], b};
    endtask

    task automatic send_frame(input logic ssc, input logic [1:0] n, input logic [M_W-1:0] m,
                              input bit live);
        logic [FRAME_LEN-1:0] fr;
        fr = {2'b00, ssc, n, m};
        for (int i = FRAME_LEN - 1; i >= 0; i--) send_bit(fr[i], live);
    endtask

    task automatic t_reset;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        chk_cfg("R1 reset", 200, 1, 0);
        chk("R1 reset range", 32'(m_out_of_range_o), 0);
        tick(5);
        chk_cfg("R1 after reset", 200, 1, 0);
        chk("R11 idle div_reset", 32'(div_reset_o), 0);
    endtask

    task automatic t_parallel;
        par_load_n_i = 1'b0;
        par_m_i = 9'd130;
        tick(LAT);
        chk_cfg("R2 follow 130", 130, 1, 0);
        par_m_i = 9'd400;
        tick(LAT);
        chk("R2 follow 400", 32'(m_div_o), 400);
        chk("R12 above max", 32'(m_out_of_range_o), 1);
        par_m_i = 9'd124;
        tick(LAT);
        chk("R12 below min", 32'(m_out_of_range_o), 1);
        par_m_i = 9'd125;
        tick(LAT);
        chk("R12 at min", 32'(m_out_of_range_o), 0);
        par_m_i = 9'd350;
        tick(LAT);
        chk("R12 at max", 32'(m_out_of_range_o), 0);
        par_m_i = 9'd351;
        tick(LAT);
        chk("R12 max plus one", 32'(m_out_of_range_o), 1);
        par_m_i = 9'd300;
        tick(LAT);
        par_load_n_i = 1'b1;
        tick(LAT);
        par_m_i = 9'd50;
        tick(6);
        chk_cfg("R3 captured", 300, 1, 0);
    endtask

    task automatic t_serial_latched;
        send_frame(1'b1, 2'b11, 9'd250, 1'b1);
        chk_cfg("R5 no change while load low", 300, 1, 0);
        ser_load_i = 1'b1;
        tick(LAT + 1);
        chk_cfg("R7 transfer frame", 250, 3, 1);
        chk("R6 field check M", 32'(m_div_o), 32'(sr_model[8:0]));
        ser_load_i = 1'b0;
        tick(LAT + 1);
        send_frame(1'b0, 2'b00, 9'd160, 1'b1);
        chk_cfg("R9 latched after fall", 250, 3, 1);
        ser_load_i = 1'b1;
        tick(LAT + 1);
        chk_cfg("R7 second transfer", 160, 0, 0);
        ser_load_i = 1'b0;
        tick(LAT + 1);
    endtask

    task automatic t_par_override;
        send_frame(1'b1, 2'b10, 9'd180, 1'b1);
        ser_load_i = 1'b1;
        tick(LAT + 1);
        chk_cfg("R7 frame C", 180, 2, 1);
        ser_load_i = 1'b0;
        tick(LAT + 1);
        par_m_i = 9'd222;
        par_load_n_i = 1'b0;
        tick(LAT + 1);
        chk_cfg("R4 parallel forces N", 222, 1, 1);
        send_frame(1'b0, 2'b11, 9'd99, 1'b0);
        ser_load_i = 1'b1;
        tick(LAT + 1);
        ser_load_i = 1'b0;
        tick(LAT + 1);
        chk_cfg("R10 serial ignored in parallel", 222, 1, 1);
        par_load_n_i = 1'b1;
        tick(LAT + 1);
        ser_load_i = 1'b1;
        tick(LAT + 1);
        chk_cfg("R10 shift register untouched", 180, 2, 1);
    endtask

    task automatic t_transparent;
        logic [3:0] bits;
        bits = 4'b1011;
        for (int i = 0; i < 4; i++) begin
            send_bit(bits[i], 1'b1);
            chk_cfg("R8 transparent shift", int'(sr_model[8:0]), int'(sr_model[10:9]),
                    int'(sr_model[11]));
        end
        ser_load_i = 1'b0;
        tick(LAT + 1);
        begin
            int m_keep;
            int n_keep;
            int s_keep;
            m_keep = int'(sr_model[8:0]);
            n_keep = int'(sr_model[10:9]);
            s_keep = int'(sr_model[11]);
            send_bit(1'b0, 1'b1);
            send_bit(1'b1, 1'b1);
            chk_cfg("R9 latched after transparent", m_keep, n_keep, s_keep);
        end
    endtask

    task automatic t_mrst;
        int m_keep;
        int n_keep;
        int s_keep;
        m_keep = int'(m_div_o);
        n_keep = int'(n_code_o);
        s_keep = int'(ssc_en_o);
        mrst_i = 1'b1;
        tick(2);
        chk("R11 div_reset asserted", 32'(div_reset_o), 1);
        tick(4);
        chk_cfg("R11 settings kept", m_keep, n_keep, s_keep);
        mrst_i = 1'b0;
        tick(2);
        chk("R11 div_reset released", 32'(div_reset_o), 0);
        chk_cfg("R11 settings kept after", m_keep, n_keep, s_keep);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        t_reset();
        t_parallel();
        t_serial_latched();
        t_par_override();
        t_transparent();
        t_mrst();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

endmodule